// File: doc/BRIEF.md
# Mailbox Firmware-Side Interrupt and Control Register File

This block is the register file that firmware uses to supervise a data-object mailbox. It sits on a plain 32-bit register bus. The bus carries a word address, a write strobe and write data, and read data comes back combinationally for the current address. The block holds an interrupt bank with three sources: a new inbound object, a requester abort and a mailbox error. Each source has a sticky state bit, an enable bit and a test-force bit. The single interrupt line is the level OR of the enabled pending sources.

The block also holds a control word and a status word. In the control word, firmware can set an abort flag and an error flag. Hardware raises the error flag when the requester makes a bad data access, and a requester abort clears it. The status word mirrors the flags of the requester side. A 4-bit multi-bit lock guards the four window registers: the inbound base and limit and the outbound base and limit. Once firmware clears the lock, those registers are frozen until reset. A range-valid flag tells the datapath that the windows can be used.

Event inputs from the datapath arrive as one-cycle pulses. Requester-side abort and bad-access indications also arrive as one-cycle pulses.

Top module: `mbx_fw_regfile`

Register offsets (byte addresses on a 6-bit bus): pending 0x00, enable 0x04, force 0x08, control 0x0C, status 0x10, lock 0x14, range-valid 0x18, inbound base 0x1C, inbound limit 0x20, outbound base 0x24, outbound limit 0x28.

## Requirements
- R1: After reset the pending, enable and control registers read 0 and the lock reads 0x6. `irq_o`, `range_valid_o` and `async_req_o` are 0, and `cfg_unlocked_o` is 1.
- R2: Pending bit 0 is new-object, bit 1 is abort and bit 2 is error. A pulse on `hw_evt_i[k]` sets bit k. Writing the pending register clears every bit written as 1 and leaves bits written as 0 untouched.
- R3: Writing 1 to bit k of the force register sets pending bit k. The force register always reads 0.
- R4: `irq_o` is a level that is 1 exactly when some pending bit and its enable bit (same position, enable register) are both 1. Clearing the enable drops `irq_o` without touching the pending bit.
- R5: When an event pulse and a firmware clear of the same pending bit fall in one cycle, the bit ends set.
- R6: Control bit 1 (error) follows firmware writes. A `sys_bad_access_i` pulse sets it and wins over a firmware write in the same cycle. A `sys_abort_i` pulse clears it and wins over both.
- R7: Control bit 0 (abort) is read/write. Control bit 3 is write-only and reads 0. Writing it as 1 makes `async_req_o` high for exactly the one cycle after the write.
- R8: Status bits 0..3 read busy, requester interrupt status, requester interrupt enable and requester async enable. Each is registered one cycle from its `sys_*` input, and busy resets to 1.
- R9: A write of v to the lock register leaves lock = lock AND v[3:0], so the lock can only lose bits. `cfg_unlocked_o` is 1 only while the lock equals 0x6, and a locked state never returns to unlocked before reset.
- R10: The four window registers store bits 31:2 and read 0 in bits 1:0. A write to them is ignored while `cfg_unlocked_o` is 0.
- R11: Range-valid bit 0 is read/write, resets to 0, drives `range_valid_o`, and is not affected by the lock.
- R12: Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| hw_evt_i | input | 3 | Event pulses: new object, abort, error |
| sys_abort_i | input | 1 | Requester abort pulse |
| sys_bad_access_i | input | 1 | Requester invalid data access pulse |
| sys_busy_i | input | 1 | Requester-side busy flag |
| sys_intr_status_i | input | 1 | Requester-side interrupt status |
| sys_intr_en_i | input | 1 | Requester-side interrupt enable |
| sys_async_en_i | input | 1 | Requester-side async message enable |
| irq_o | output | 1 | Interrupt level |
| cfg_unlocked_o | output | 1 | Window registers are writable |
| range_valid_o | output | 1 | Window configuration marked valid |
| async_req_o | output | 1 | Async message request pulse |
| ib_base_o | output | 32 | Inbound window base |
| ib_limit_o | output | 32 | Inbound window inclusive limit |
| ob_base_o | output | 32 | Outbound window base |
| ob_limit_o | output | 32 | Outbound window inclusive limit |

## Verification
The hardest conditions to reach are the same-cycle collisions. One is a datapath event landing in the very cycle that firmware clears the same pending bit. Another is a bad-access set, a firmware write and a requester abort all meeting on the control error bit. The bench drives the event or requester pulse in the same negedge window as the register write, so all of them reach one clock edge together, and then reads back the surviving value. The lock is exercised with a partial clear, which leaves the lock at 0x4. A later all-ones write then shows that the lock cannot climb back to 0x6.

// File: rtl/mbx_reg_pkg.sv
package mbx_reg_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;
  localparam int IRQ_N   = 3;
  localparam int LOCK_W  = 4;
  localparam int STAT_N  = 4;
  localparam int CFG_N   = 4;
  localparam int ALIGN_B = 2;

  localparam logic [LOCK_W-1:0] LOCK_OPEN = 4'h6;

  localparam logic [ADDR_W-1:0] OFF_IRQ_PEND = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_IRQ_EN   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_IRQ_FRC  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CTRL     = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_STATUS   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_LOCK     = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_RANGE    = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_CFG0     = 6'h1C;

  // control word bit positions
  localparam int CTRL_ABORT = 0;
  localparam int CTRL_ERROR = 1;
  localparam int CTRL_ASYNC = 3;

  typedef enum logic [1:0] {
    EVT_READY = 2'd0,
    EVT_ABORT = 2'd1,
    EVT_ERROR = 2'd2
  } evt_idx_e;
endpackage

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         pend_wr_i,
  input  logic         en_wr_i,
  input  logic         frc_wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] en_q, en_d;
  logic [N-1:0] clr_mask, set_mask;

  always_comb begin
    clr_mask = pend_wr_i ? wdata_i : '0;
    set_mask = evt_i | (frc_wr_i ? wdata_i : '0);
    // sets are applied after clears so a colliding event survives
    pend_d   = (pend_q & ~clr_mask) | set_mask;
    en_d     = en_q;
    if (en_wr_i) en_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (en_wr_i) en_q <= en_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = |(pend_q & en_q);
endmodule

// File: rtl/mbx_ctrl_stat.sv
module mbx_ctrl_stat
  import mbx_reg_pkg::*;
#(
  parameter int SN = STAT_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_wr_i,
  input  logic [3:0]    wdata_i,
  input  logic          sys_abort_i,
  input  logic          sys_bad_access_i,
  input  logic [SN-1:0] sys_flags_i,
  output logic          abort_o,
  output logic          error_o,
  output logic          async_o,
  output logic [SN-1:0] status_o
);
  localparam logic [SN-1:0] STAT_RST = SN'(1);

  logic          abort_q, abort_d;
  logic          error_q, error_d;
  logic          async_q, async_d;
  logic [SN-1:0] stat_q;

  always_comb begin
    abort_d = abort_q;
    error_d = error_q;
    if (ctrl_wr_i) begin
      abort_d = wdata_i[CTRL_ABORT];
      error_d = wdata_i[CTRL_ERROR];
    end
    if (sys_bad_access_i) error_d = 1'b1;
    if (sys_abort_i)      error_d = 1'b0;
    async_d = ctrl_wr_i & wdata_i[CTRL_ASYNC];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_q <= 1'b0;
      error_q <= 1'b0;
      async_q <= 1'b0;
      stat_q  <= STAT_RST;
    end else begin
      if (ctrl_wr_i) abort_q <= abort_d;
      error_q <= error_d;
      async_q <= async_d;
      stat_q  <= sys_flags_i;
    end
  end

  assign abort_o  = abort_q;
  assign error_o  = error_q;
  assign async_o  = async_q;
  assign status_o = stat_q;
endmodule

// File: rtl/mbx_cfg_guard.sv
module mbx_cfg_guard
  import mbx_reg_pkg::*;
#(
  parameter int NW = CFG_N,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [LOCK_W-1:0]     lock_o,
  output logic                  unlocked_o,
  output logic                  range_valid_o,
  output logic [NW-1:0][DW-1:0] cfg_o
);
  localparam int KEEP_W = DW - ALIGN_B;

  logic [LOCK_W-1:0] lock_q, lock_d;
  logic              lock_wr, range_wr;
  logic              range_q, range_d;
  logic              unlocked;

  assign unlocked = (lock_q == LOCK_OPEN);
  assign lock_wr  = wr_i && (addr_i == OFF_LOCK);
  assign range_wr = wr_i && (addr_i == OFF_RANGE);

  always_comb begin
    lock_d  = lock_q & wdata_i[LOCK_W-1:0];
    range_d = wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= LOCK_OPEN;
      range_q <= 1'b0;
    end else begin
      if (lock_wr)  lock_q  <= lock_d;
      if (range_wr) range_q <= range_d;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_win
    logic [KEEP_W-1:0] win_q, win_d;
    logic              win_wr;

    assign win_wr = wr_i && unlocked && (addr_i == OFF_CFG0 + AW'(4 * g));

    always_comb win_d = wdata_i[DW-1:ALIGN_B];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     win_q <= '0;
      else if (win_wr) win_q <= win_d;
    end

    assign cfg_o[g] = {win_q, {ALIGN_B{1'b0}}};
  end

  assign lock_o        = lock_q;
  assign unlocked_o    = unlocked;
  assign range_valid_o = range_q;
endmodule

// File: rtl/mbx_fw_regfile.sv
module mbx_fw_regfile
  import mbx_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [IRQ_N-1:0]  hw_evt_i,
  input  logic              sys_abort_i,
  input  logic              sys_bad_access_i,
  input  logic              sys_busy_i,
  input  logic              sys_intr_status_i,
  input  logic              sys_intr_en_i,
  input  logic              sys_async_en_i,
  output logic              irq_o,
  output logic              cfg_unlocked_o,
  output logic              range_valid_o,
  output logic              async_req_o,
  output logic [DATA_W-1:0] ib_base_o,
  output logic [DATA_W-1:0] ib_limit_o,
  output logic [DATA_W-1:0] ob_base_o,
  output logic [DATA_W-1:0] ob_limit_o
);
  logic [IRQ_N-1:0]             irq_pend, irq_en;
  logic                         ctrl_abort, ctrl_error;
  logic [STAT_N-1:0]            status;
  logic [LOCK_W-1:0]            lock_val;
  logic [CFG_N-1:0][DATA_W-1:0] cfg;

  logic pend_wr, en_wr, frc_wr, ctrl_wr;
  assign pend_wr = reg_wr_i && (reg_addr_i == OFF_IRQ_PEND);
  assign en_wr   = reg_wr_i && (reg_addr_i == OFF_IRQ_EN);
  assign frc_wr  = reg_wr_i && (reg_addr_i == OFF_IRQ_FRC);
  assign ctrl_wr = reg_wr_i && (reg_addr_i == OFF_CTRL);

  mbx_irq_bank #(.N(IRQ_N)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (hw_evt_i),
    .pend_wr_i (pend_wr),
    .en_wr_i   (en_wr),
    .frc_wr_i  (frc_wr),
    .wdata_i   (reg_wdata_i[IRQ_N-1:0]),
    .pend_o    (irq_pend),
    .en_o      (irq_en),
    .irq_o     (irq_o)
  );

  mbx_ctrl_stat #(.SN(STAT_N)) u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .ctrl_wr_i        (ctrl_wr),
    .wdata_i          (reg_wdata_i[3:0]),
    .sys_abort_i      (sys_abort_i),
    .sys_bad_access_i (sys_bad_access_i),
    .sys_flags_i      ({sys_async_en_i, sys_intr_en_i, sys_intr_status_i, sys_busy_i}),
    .abort_o          (ctrl_abort),
    .error_o          (ctrl_error),
    .async_o          (async_req_o),
    .status_o         (status)
  );

  mbx_cfg_guard #(.NW(CFG_N), .AW(ADDR_W), .DW(DATA_W)) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (reg_wr_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .lock_o        (lock_val),
    .unlocked_o    (cfg_unlocked_o),
    .range_valid_o (range_valid_o),
    .cfg_o         (cfg)
  );

  assign ib_base_o  = cfg[0];
  assign ib_limit_o = cfg[1];
  assign ob_base_o  = cfg[2];
  assign ob_limit_o = cfg[3];

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_IRQ_PEND: reg_rdata_o[IRQ_N-1:0]  = irq_pend;
      OFF_IRQ_EN:   reg_rdata_o[IRQ_N-1:0]  = irq_en;
      OFF_CTRL: begin
        reg_rdata_o[CTRL_ABORT] = ctrl_abort;
        reg_rdata_o[CTRL_ERROR] = ctrl_error;
      end
      OFF_STATUS:   reg_rdata_o[STAT_N-1:0] = status;
      OFF_LOCK:     reg_rdata_o[LOCK_W-1:0] = lock_val;
      OFF_RANGE:    reg_rdata_o[0]          = range_valid_o;
      default: begin
        for (int k = 0; k < CFG_N; k++) begin
          if (reg_addr_i == OFF_CFG0 + ADDR_W'(4 * k)) reg_rdata_o = cfg[k];
        end
      end
    endcase
  end
endmodule

// File: rtl/mbx_fw_regfile_chk.sv
module mbx_fw_regfile_chk
  import mbx_reg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [IRQ_N-1:0]  hw_evt_i,
  input logic [IRQ_N-1:0]  irq_pend,
  input logic [IRQ_N-1:0]  irq_en,
  input logic              irq_o,
  input logic              ctrl_error,
  input logic              sys_abort_i,
  input logic              sys_bad_access_i,
  input logic              cfg_unlocked_o,
  input logic [DATA_W-1:0] ib_base_o,
  input logic [DATA_W-1:0] ob_limit_o,
  input logic              async_req_o
);
  AST_EVT_SURVIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_evt_i) |=> ((irq_pend & $past(hw_evt_i)) == $past(hw_evt_i))); // R5

  AST_IRQ_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(hw_evt_i & irq_en)) && !(reg_wr_i && reg_addr_i == OFF_IRQ_EN)) |=> irq_o); // R4

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend == '0) |-> !irq_o); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_unlocked_o |=> !cfg_unlocked_o); // R9

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_unlocked_o |=> ($stable(ib_base_o) && $stable(ob_limit_o))); // R10

  AST_ERR_ABORT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_abort_i |=> !ctrl_error); // R6

  AST_ERR_HW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_bad_access_i && !sys_abort_i) |=> ctrl_error); // R6

  AST_ASYNC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    async_req_o |-> $past(reg_wr_i && reg_addr_i == OFF_CTRL && reg_wdata_i[CTRL_ASYNC])); // R7
endmodule

bind mbx_fw_regfile mbx_fw_regfile_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .reg_wr_i         (reg_wr_i),
  .reg_addr_i       (reg_addr_i),
  .reg_wdata_i      (reg_wdata_i),
  .hw_evt_i         (hw_evt_i),
  .irq_pend         (irq_pend),
  .irq_en           (irq_en),
  .irq_o            (irq_o),
  .ctrl_error       (ctrl_error),
  .sys_abort_i      (sys_abort_i),
  .sys_bad_access_i (sys_bad_access_i),
  .cfg_unlocked_o   (cfg_unlocked_o),
  .ib_base_o        (ib_base_o),
  .ob_limit_o       (ob_limit_o),
  .async_req_o      (async_req_o)
);

// File: tb/mbx_fw_regfile_test.sv
module mbx_fw_regfile_test;
  import mbx_reg_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              we;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic [IRQ_N-1:0]  evt;
  logic              s_abort, s_bad, s_busy, s_ist, s_ien, s_aen;
  logic              irq, unlocked, rvalid, async_req;
  logic [DATA_W-1:0] ib_base, ib_limit, ob_base, ob_limit;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mbx_fw_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .hw_evt_i(evt),
    .sys_abort_i(s_abort), .sys_bad_access_i(s_bad), .sys_busy_i(s_busy),
    .sys_intr_status_i(s_ist), .sys_intr_en_i(s_ien), .sys_async_en_i(s_aen),
    .irq_o(irq), .cfg_unlocked_o(unlocked), .range_valid_o(rvalid),
    .async_req_o(async_req), .ib_base_o(ib_base), .ib_limit_o(ib_limit),
    .ob_base_o(ob_base), .ob_limit_o(ob_limit)
  );

  // {write enable, write address, write data, read address, expected read}
  localparam int NV = 15;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, OFF_IRQ_PEND, 32'h0000_0000, OFF_STATUS,   32'h0000_0001}, // R8
    {1'b0, OFF_IRQ_PEND, 32'h0000_0000, OFF_LOCK,     32'h0000_0006}, // R9
    {1'b1, OFF_IRQ_EN,   32'h0000_0007, OFF_IRQ_EN,   32'h0000_0007}, // R4
    {1'b1, OFF_IRQ_FRC,  32'h0000_0005, OFF_IRQ_PEND, 32'h0000_0005}, // R3
    {1'b1, OFF_IRQ_FRC,  32'h0000_0002, OFF_IRQ_FRC,  32'h0000_0000}, // R3
    {1'b1, OFF_IRQ_PEND, 32'h0000_0001, OFF_IRQ_PEND, 32'h0000_0006}, // R2
    {1'b1, OFF_IRQ_PEND, 32'h0000_0000, OFF_IRQ_PEND, 32'h0000_0006}, // R2
    {1'b1, OFF_IRQ_PEND, 32'h0000_0006, OFF_IRQ_PEND, 32'h0000_0000}, // R2
    {1'b1, OFF_CFG0,     32'h1234_5677, OFF_CFG0,     32'h1234_5674}, // R10
    {1'b1, 6'h28,        32'hFFFF_FFFF, 6'h28,        32'hFFFF_FFFC}, // R10
    {1'b1, OFF_RANGE,    32'hFFFF_FFFF, OFF_RANGE,    32'h0000_0001}, // R11
    {1'b1, OFF_CTRL,     32'h0000_000B, OFF_CTRL,     32'h0000_0003}, // R7
    {1'b1, OFF_CTRL,     32'h0000_0000, OFF_CTRL,     32'h0000_0000}, // R6
    {1'b1, 6'h3C,        32'hFFFF_FFFF, 6'h3C,        32'h0000_0000}, // R12
    {1'b1, OFF_LOCK,     32'h0000_000E, OFF_LOCK,     32'h0000_0006}  // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
    we = 1'b0;
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; evt = '0;
    s_abort = 1'b0; s_bad = 1'b0; s_busy = 1'b1;
    s_ist = 1'b0; s_ien = 1'b0; s_aen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 unlocked", {31'b0, unlocked}, 32'h1);
    check("R1 range", {31'b0, rvalid}, 32'h0);
    check("R1 async", {31'b0, async_req}, 32'h0);
    rd(OFF_IRQ_PEND, 32'h0, "R1 pend");
    rd(OFF_IRQ_EN,   32'h0, "R1 enable");
    rd(OFF_CTRL,     32'h0, "R1 ctrl");
    rd(OFF_LOCK,     32'h6, "R1 lock");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we = VEC[i][76]; addr = VEC[i][75:70]; wdata = VEC[i][69:38];
      @(negedge clk);
      rd(VEC[i][37:32], VEC[i][31:0], $sformatf("R vector %0d", i));
    end

    // R4 / R2: event pulse raises a level interrupt
    @(negedge clk); evt = 3'b010;
    @(negedge clk); evt = 3'b000;
    check("R4 irq after abort event", {31'b0, irq}, 32'h1);
    rd(OFF_IRQ_PEND, 32'h2, "R2 event sets bit1");
    wr(OFF_IRQ_EN, 32'h0);
    check("R4 irq masked", {31'b0, irq}, 32'h0);
    rd(OFF_IRQ_PEND, 32'h2, "R4 pend kept while masked");
    wr(OFF_IRQ_EN, 32'h2);
    check("R4 irq re-enabled", {31'b0, irq}, 32'h1);
    wr(OFF_IRQ_PEND, 32'h2);
    check("R4 irq after clear", {31'b0, irq}, 32'h0);

    // R5: event collides with clear
    @(negedge clk); evt = 3'b001; we = 1'b1; addr = OFF_IRQ_PEND; wdata = 32'h1;
    @(negedge clk); evt = 3'b000; we = 1'b0;
    rd(OFF_IRQ_PEND, 32'h1, "R5 event beats clear");
    wr(OFF_IRQ_PEND, 32'h1);
    rd(OFF_IRQ_PEND, 32'h0, "R2 clear bit0");

    // R6: error bit sources
    @(negedge clk); s_bad = 1'b1;
    @(negedge clk); s_bad = 1'b0;
    rd(OFF_CTRL, 32'h2, "R6 hw set");
    @(negedge clk); s_abort = 1'b1;
    @(negedge clk); s_abort = 1'b0;
    rd(OFF_CTRL, 32'h0, "R6 abort clears");
    @(negedge clk); s_abort = 1'b1; s_bad = 1'b1;
    @(negedge clk); s_abort = 1'b0; s_bad = 1'b0;
    rd(OFF_CTRL, 32'h0, "R6 abort beats set");
    wr(OFF_CTRL, 32'h2);
    rd(OFF_CTRL, 32'h2, "R6 fw set");
    @(negedge clk); s_bad = 1'b1; we = 1'b1; addr = OFF_CTRL; wdata = 32'h0;
    @(negedge clk); s_bad = 1'b0; we = 1'b0;
    rd(OFF_CTRL, 32'h2, "R6 hw beats fw clear");
    @(negedge clk); s_abort = 1'b1;
    @(negedge clk); s_abort = 1'b0;
    rd(OFF_CTRL, 32'h0, "R6 abort clears again");

    // R7: async request pulse
    @(negedge clk); we = 1'b1; addr = OFF_CTRL; wdata = 32'h8;
    @(negedge clk); we = 1'b0;
    check("R7 async high", {31'b0, async_req}, 32'h1);
    rd(OFF_CTRL, 32'h0, "R7 async reads 0");
    @(negedge clk);
    check("R7 async one cycle", {31'b0, async_req}, 32'h0);

    // R8: status mirrors
    s_busy = 1'b0; s_ist = 1'b1; s_ien = 1'b1; s_aen = 1'b1;
    @(negedge clk);
    rd(OFF_STATUS, 32'hE, "R8 status mirror");

    // R9 / R10: lock
    wr(OFF_LOCK, 32'h4);
    rd(OFF_LOCK, 32'h4, "R9 partial clear");
    check("R9 locked out", {31'b0, unlocked}, 32'h0);
    wr(OFF_CFG0, 32'hAAAA_AAA8);
    rd(OFF_CFG0, 32'h1234_5674, "R10 base ignored when locked");
    check("R10 base port", ib_base, 32'h1234_5674);
    wr(OFF_LOCK, 32'hF);
    rd(OFF_LOCK, 32'h4, "R9 no relock");
    wr(OFF_LOCK, 32'h0);
    rd(OFF_LOCK, 32'h0, "R9 full clear");

    // R11: range valid, unaffected by lock
    check("R11 range port", {31'b0, rvalid}, 32'h1);
    wr(OFF_RANGE, 32'h0);
    check("R11 range cleared", {31'b0, rvalid}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule